// File: doc/BRIEF.md
# Prioritized Sticky Error Status Register

This block gathers level-sensitive error causes from a serial I/O network controller and turns them into one 8-bit status byte that a host can read. The low nibble holds the number of the reported error (0 to 6) and bit 7 shows whether an error is present now. When several causes are asserted together, the lowest-numbered one is reported. Error 1 therefore wins over error 2, and both win over errors 3 to 6.

Errors 1 to 6 recover on their own: bit 7 drops when the cause goes away, but the error number stays in the low nibble so the host can still see what happened. Error 0 is a fault of the control board itself. Once it is seen it holds the byte at 0x80 until reset. The host erases a kept error number with a one-cycle clear strobe. The clear is accepted only while bit 7 reads 0, and an accepted clear is confirmed by a one-cycle done pulse back to the command logic.

Top module: `err_status_reg`

## Requirements
- R1: `status_o[3:0]` holds the reported error number and is never above 6, and `status_o[6:4]` always reads 0. Input `cause_i[k]` stands for error k. Every input is sampled on a rising clock edge and shows in `status_o` right after that edge.
- R2: One cycle after any of `cause_i[6:1]` is high, `status_o[7]` is 1. One cycle after all of them are low, it is 0, unless error 0 is latched.
- R3: A high `cause_i[0]` latches error 0. From the next cycle until reset, `status_o` reads 0x80, whatever the other causes or clear requests do.
- R4: When several of causes 1 to 6 are high, the lowest-numbered one is reported. Error 1 outranks error 2, and both outrank errors 3 to 6.
- R5: A newly arising higher-priority error replaces the kept number. A lower-priority error does not replace a number whose cause is still high. Once the kept cause has gone, the highest-priority cause still high is loaded.
- R6: When the causes of errors 1 to 6 drop, `status_o[7]` returns to 0 and `status_o[3:0]` keeps its value.
- R7: If `clr_req_i` is high at an edge where `status_o[7]` is 0, the number becomes 0 and `clr_done_o` is 1 for exactly the following cycle.
- R8: If `clr_req_i` is high while `status_o[7]` is 1, the request is ignored: the byte is unchanged by it and `clr_done_o` stays 0.
- R9: An accepted clear that coincides with a newly asserted cause still pulses `clr_done_o`, but the new error number is loaded, not 0.
- R10: After reset, `status_o` is 0x00 and `clr_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cause_i | input | 7 | Level error causes; bit k is error k |
| clr_req_i | input | 1 | One-cycle request to erase the kept error number |
| status_o | output | 8 | {active, 3'b000, error number} |
| clr_done_o | output | 1 | One-cycle pulse confirming an accepted clear |

## Verification
Both results are one register stage deep. The status byte and the clear-done pulse both reflect the inputs sampled at the previous rising edge. The bench drives each input set on a falling edge and compares both outputs on the next falling edge, exactly one rising edge later. Sticky, refused and concurrent-clear cases are covered by follow-up rows, which show that the byte persists or that the pulse lasts only one cycle.

// File: rtl/err_status_pkg.sv
package err_status_pkg;
  localparam int unsigned NUM_CAUSES = 7;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned STAT_W     = 8;
endpackage

// File: rtl/err_prio_enc.sv
module err_prio_enc #(
  parameter int unsigned NUM_CAUSES = 7,
  parameter int unsigned CODE_W     = 4
) (
  input  logic [NUM_CAUSES-1:0] cause_i,
  output logic                  any_o,
  output logic [CODE_W-1:0]     code_o
);
  // causes 1..N-1 only; cause 0 is handled by the latch
  always_comb begin
    code_o = '0;
    for (int k = NUM_CAUSES - 1; k >= 1; k--) begin
      if (cause_i[k]) code_o = CODE_W'(k);
    end
  end

  assign any_o = |cause_i[NUM_CAUSES-1:1];
endmodule

// File: rtl/err_code_hold.sv
module err_code_hold #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_set_i,
  input  logic              any_i,
  input  logic [CODE_W-1:0] win_code_i,
  input  logic              clr_take_i,
  output logic [CODE_W-1:0] code_o,
  output logic              active_o
);
  logic              sys_q;
  logic              sys_d;
  logic [CODE_W-1:0] code_q;
  logic              active_q;

  assign sys_d = sys_q | sys_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q    <= 1'b0;
      code_q   <= '0;
      active_q <= 1'b0;
    end else begin
      sys_q    <= sys_d;
      active_q <= sys_d | any_i;
      if (sys_d)           code_q <= '0;
      else if (any_i)      code_q <= win_code_i;
      else if (clr_take_i) code_q <= '0;
    end
  end

  assign code_o   = code_q;
  assign active_o = active_q;
endmodule

// File: rtl/err_clear_ctrl.sv
module err_clear_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_req_i,
  input  logic active_i,
  output logic take_o,
  output logic done_o
);
  logic done_q;

  assign take_o = clr_req_i & ~active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= take_o;
  end

  assign done_o = done_q;
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_status_pkg::*;
#(
  parameter int unsigned N_CAUSE = NUM_CAUSES,
  parameter int unsigned C_W     = CODE_W,
  parameter int unsigned S_W     = STAT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAUSE-1:0] cause_i,
  input  logic               clr_req_i,
  output logic [S_W-1:0]     status_o,
  output logic               clr_done_o
);
  localparam int unsigned PAD_W = S_W - 1 - C_W;

  logic           any;
  logic [C_W-1:0] win_code;
  logic [C_W-1:0] code;
  logic           active;
  logic           clr_take;

  err_prio_enc #(.NUM_CAUSES(N_CAUSE), .CODE_W(C_W)) u_enc (
    .cause_i (cause_i),
    .any_o   (any),
    .code_o  (win_code)
  );

  err_code_hold #(.CODE_W(C_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_set_i  (cause_i[0]),
    .any_i      (any),
    .win_code_i (win_code),
    .clr_take_i (clr_take),
    .code_o     (code),
    .active_o   (active)
  );

  err_clear_ctrl u_clr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_req_i (clr_req_i),
    .active_i  (active),
    .take_o    (clr_take),
    .done_o    (clr_done_o)
  );

  assign status_o = {active, {PAD_W{1'b0}}, code};
endmodule

// File: rtl/err_status_chk.sv
module err_status_chk #(
  parameter int unsigned N_CAUSE = 7,
  parameter int unsigned S_W     = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CAUSE-1:0] cause_i,
  input logic               clr_req_i,
  input logic [S_W-1:0]     status_o,
  input logic               clr_done_o
);
  logic sys_view;
  assign sys_view = status_o[S_W-1] && (status_o[3:0] == 4'd0);

  // R1
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3:0] <= 4'd6);

  // R2
  active_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_i[N_CAUSE-1:1]) |=> status_o[S_W-1]);

  // R3
  sys_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_view |=> sys_view);

  // R4
  prio_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i[1] && !cause_i[0] && !sys_view) |=> (status_o[3:0] == 4'd1));

  // R6
  code_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i == '0 && !clr_req_i) |=> $stable(status_o[3:0]));

  // R7
  clr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req_i && !status_o[S_W-1] && cause_i == '0) |=> (status_o == '0 && clr_done_o));

  // R8
  clr_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req_i && status_o[S_W-1]) |=> !clr_done_o);
endmodule

bind err_status_reg err_status_chk #(.N_CAUSE(N_CAUSE), .S_W(S_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cause_i    (cause_i),
  .clr_req_i  (clr_req_i),
  .status_o   (status_o),
  .clr_done_o (clr_done_o)
);

// File: tb/err_status_reg_bench.sv
`timescale 1ns/1ps
module err_status_reg_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] cause_i = '0;
  logic       clr_req_i = 1'b0;
  logic [7:0] status_o;
  logic       clr_done_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #2 clk_i = ~clk_i;

  err_status_reg u_err_status_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .cause_i(cause_i),
    .clr_req_i(clr_req_i), .status_o(status_o), .clr_done_o(clr_done_o)
  );

  // {cause[6:0], clr, expected status, expected done}
  localparam int NV = 20;
  localparam logic [16:0] VEC [NV] = '{
    {7'b0000000, 1'b0, 8'h00, 1'b0},  // R10 idle
    {7'b0001000, 1'b0, 8'h83, 1'b0},  // R2
    {7'b0101000, 1'b0, 8'h83, 1'b0},  // R5 lower keeps out
    {7'b0100000, 1'b0, 8'h85, 1'b0},  // R5 kept cause gone
    {7'b0100100, 1'b0, 8'h82, 1'b0},  // R4
    {7'b0000110, 1'b0, 8'h81, 1'b0},  // R4 one over two
    {7'b0000000, 1'b0, 8'h01, 1'b0},  // R6
    {7'b0000000, 1'b1, 8'h00, 1'b1},  // R7
    {7'b0000000, 1'b0, 8'h00, 1'b0},  // R7 pulse ends
    {7'b0010000, 1'b0, 8'h84, 1'b0},  // R2
    {7'b0010000, 1'b1, 8'h84, 1'b0},  // R8
    {7'b0000000, 1'b0, 8'h04, 1'b0},  // R6
    {7'b1000000, 1'b1, 8'h86, 1'b1},  // R9
    {7'b0000000, 1'b0, 8'h06, 1'b0},  // R6
    {7'b1001100, 1'b0, 8'h82, 1'b0},  // R4
    {7'b0000000, 1'b0, 8'h02, 1'b0},  // R6
    {7'b0000001, 1'b0, 8'h80, 1'b0},  // R3
    {7'b0000000, 1'b0, 8'h80, 1'b0},  // R3 latched
    {7'b0000010, 1'b1, 8'h80, 1'b0},  // R3 clear refused
    {7'b0000000, 1'b0, 8'h80, 1'b0}   // R3
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R10";
      1, 9: return "R2";
      2, 3: return "R5";
      4, 5, 14: return "R4";
      6, 11, 13, 15: return "R6";
      7, 8: return "R7";
      10: return "R8";
      12: return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] exp_s, logic exp_d);
    n_chk++;
    if (status_o !== exp_s || status_o[6:4] !== 3'b000) begin
      n_fail++;
      $display("FAIL %s (R1 layout) status actual=%h expected=%h", req, status_o, exp_s);
    end
    n_chk++;
    if (clr_done_o !== exp_d) begin
      n_fail++;
      $display("FAIL %s clr_done actual=%b expected=%b", req, clr_done_o, exp_d);
    end
  endtask

  task automatic step(logic [6:0] c, logic r);
    cause_i   = c;
    clr_req_i = r;
    @(negedge clk_i);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10", 8'h00, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16:10], VEC[i][9]);
      check(vec_req(i), VEC[i][8:1], VEC[i][0]);
    end
    // R3: still latched with every cause and clear high
    step(7'b1111110, 1'b1);
    check("R3", 8'h80, 1'b0);
    step(7'b0000000, 1'b0);
    // R10: reset drops the latched error 0
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R10", 8'h00, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(7'b0000000, 1'b0);
    check("R10", 8'h00, 1'b0);
    // R4 after reset: error 1 beats 6
    step(7'b1000010, 1'b0);
    check("R4", 8'h81, 1'b0);
    // R5: higher-priority arrival overwrites a still-active 6
    step(7'b1000000, 1'b0);
    check("R5", 8'h86, 1'b0);
    step(7'b1001000, 1'b0);
    check("R5", 8'h83, 1'b0);
    step(7'b0000000, 1'b0);
    check("R6", 8'h03, 1'b0);
    step(7'b0000000, 1'b1);
    check("R7", 8'h00, 1'b1);
    finish_up();
  end
endmodule